// File: doc/BRIEF.md
# Line Alarm Monitor

This block watches two activity sources at the line interface of a PCM transceiver and raises two alarms. The receive alarm reports loss of signal: it counts bit periods of the recovered clock in which neither mark indicator is set. The driver alarm reports a silent transmit monitor: it counts bit periods in which the monitor reports no activity. Each alarm is a live level that clears as soon as its source shows activity again.

Every alarm also has a sticky status bit. The bit is set when the alarm rises and is held until the host clears it. An active-low interrupt, meant for an open-drain pad, is pulled low while any status bit is set. A clear request is honoured only while the alarm is inactive. A condition that is still present therefore cannot be cleared by mistake.

Top module: `alarm_monitor`

## Requirements
- R1: `los_o` is low after 174 consecutive space periods and goes high in the period after the 175th consecutive space. A space is a rising clock edge with `mark_p_i` and `mark_n_i` both low.
- R2: A mark on either `mark_p_i` or `mark_n_i`, sampled at one edge, drives `los_o` low right after that edge and restarts the space count from zero.
- R3: `dpm_o` is low after 62 consecutive edges with `mon_act_i` low and goes high after the 63rd.
- R4: `dpm_o` stays high for as long as `mon_act_i` stays low. It drops right after the first edge at which `mon_act_i` is high.
- R5: A status bit (`los_stat_o`, `dpm_stat_o`) goes high one edge after its alarm rises. `irq_no` is low exactly while at least one status bit is high.
- R6: A clear input (`clr_los_i`, `clr_dpm_i`) sampled high while its alarm is low clears the status bit at that edge. `irq_no` returns high once both bits are clear.
- R7: A clear input sampled while its alarm is high is ignored, and the status bit stays high.
- R8: The silence counters saturate. While silence continues past the threshold, the alarms stay high for hundreds of periods without wrapping.
- R9: After reset, both alarms and both status bits are low and `irq_no` is high.
- R10: The two channels are independent. Clearing one status bit or restoring one source leaves the other alarm and status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mark_p_i | input | 1 | Positive mark seen in this bit period |
| mark_n_i | input | 1 | Negative mark seen in this bit period |
| mon_act_i | input | 1 | Transmit monitor saw a pulse in this period |
| clr_los_i | input | 1 | Host clear request for the receive status bit |
| clr_dpm_i | input | 1 | Host clear request for the driver status bit |
| los_o | output | 1 | Live loss-of-signal alarm |
| dpm_o | output | 1 | Live driver monitor alarm |
| los_stat_o | output | 1 | Sticky receive alarm status |
| dpm_stat_o | output | 1 | Sticky driver alarm status |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The first pattern is long runs of silence stopped one period before each threshold and then carried one period past it. This separates an exact threshold from one that is off by one, and the continued silence exposes a counter that wraps. Single marks on each polarity and single monitor pulses show that one event is enough to restore an alarm and that both mark inputs count. Clear pulses are sent while the alarm is still high, after it has dropped, and on one channel at a time; these tell apart clears that are ignored, honoured, or leaking into the other channel. A final stretch of random marks, activity and clears at several densities is compared period by period against the reference model.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned LOS_SPACES = 175;
  localparam int unsigned DPM_IDLE   = 63;
  localparam int unsigned NUM_CH     = 2;
  localparam int unsigned CH_LOS     = 0;
  localparam int unsigned CH_DPM     = 1;
endpackage

// File: rtl/silence_counter.sv
module silence_counter #(
  parameter int unsigned LIMIT = 175
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic activity_i,
  output logic alarm_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  // saturates at LIM; any activity restarts from zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (activity_i)      cnt_q <= '0;
    else if (cnt_q != LIM)    cnt_q <= cnt_q + CW'(1);
  end

  assign alarm_o = (cnt_q == LIM);

  // R2 / R4: one active period restores the alarm
  assert_drop_on_activity_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activity_i |=> !alarm_o);
  // R8: no wrap while silence continues
  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && !activity_i) |=> alarm_o);
  // R1 / R3: alarm only rises out of a silent period
  assert_rise_after_silence_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> $past(!activity_i));
endmodule

// File: rtl/sticky_status.sv
module sticky_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alarm_i,
  input  logic clr_i,
  output logic stat_o
);
  logic alarm_d_q;
  logic stat_q;
  logic rise;

  assign rise = alarm_i && !alarm_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_d_q <= 1'b0;
      stat_q    <= 1'b0;
    end else begin
      alarm_d_q <= alarm_i;
      if (rise)                   stat_q <= 1'b1;
      else if (clr_i && !alarm_i) stat_q <= 1'b0;
    end
  end

  assign stat_o = stat_q;

  assert_set_on_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_i) |=> stat_o);
  assert_clear_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o && alarm_i) |=> stat_o);
  assert_clear_honoured_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !alarm_i) |=> !stat_o);
endmodule

// File: rtl/alarm_monitor.sv
module alarm_monitor
  import alarm_pkg::*;
#(
  parameter int unsigned LOS_LIMIT = LOS_SPACES,
  parameter int unsigned DPM_LIMIT = DPM_IDLE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mark_p_i,
  input  logic mark_n_i,
  input  logic mon_act_i,
  input  logic clr_los_i,
  input  logic clr_dpm_i,
  output logic los_o,
  output logic dpm_o,
  output logic los_stat_o,
  output logic dpm_stat_o,
  output logic irq_no
);
  logic [NUM_CH-1:0] act, clr, alarm, stat;

  assign act[CH_LOS] = mark_p_i | mark_n_i;
  assign act[CH_DPM] = mon_act_i;
  assign clr[CH_LOS] = clr_los_i;
  assign clr[CH_DPM] = clr_dpm_i;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int unsigned LIM = (i == CH_LOS) ? LOS_LIMIT : DPM_LIMIT;
    silence_counter #(.LIMIT(LIM)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .activity_i (act[i]),
      .alarm_o    (alarm[i])
    );
    sticky_status u_stat (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .alarm_i (alarm[i]),
      .clr_i   (clr[i]),
      .stat_o  (stat[i])
    );
  end

  assign los_o      = alarm[CH_LOS];
  assign dpm_o      = alarm[CH_DPM];
  assign los_stat_o = stat[CH_LOS];
  assign dpm_stat_o = stat[CH_DPM];
  assign irq_no     = ~|stat;

  // R10: a clear on one channel never touches the other status bit
  assert_ch_indep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_los_i && !clr_dpm_i && dpm_stat_o) |=> dpm_stat_o);
  // R5: interrupt low while any status is pending
  assert_irq_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(los_o) |=> (los_stat_o && !irq_no));
endmodule

// File: tb/sim_alarm_monitor.sv
`timescale 1ns/1ps
module sim_alarm_monitor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mp = 0, mn = 0, ma = 0, cl = 0, cd = 0;
  logic los, dpm, los_s, dpm_s, irq_n;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  alarm_monitor u0 (
    .clk_i(clk), .rst_ni(rst_n), .mark_p_i(mp), .mark_n_i(mn), .mon_act_i(ma),
    .clr_los_i(cl), .clr_dpm_i(cd), .los_o(los), .dpm_o(dpm),
    .los_stat_o(los_s), .dpm_stat_o(dpm_s), .irq_no(irq_n)
  );

  // behavioural reference model
  int sc = 0, mc = 0;
  bit m_ld = 0, m_dd = 0, m_ls = 0, m_ds = 0;
  function automatic bit m_los(); return sc >= 175; endfunction
  function automatic bit m_dpm(); return mc >= 63;  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc = 0; mc = 0; m_ld = 0; m_dd = 0; m_ls = 0; m_ds = 0;
    end else begin
      bit a_l, a_d;
      a_l = m_los(); a_d = m_dpm();
      if (a_l && !m_ld) m_ls = 1; else if (cl && !a_l) m_ls = 0;
      if (a_d && !m_dd) m_ds = 1; else if (cd && !a_d) m_ds = 0;
      m_ld = a_l; m_dd = a_d;
      if (mp || mn) sc = 0; else sc++;
      if (ma) mc = 0; else mc++;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R1 los_o", los, m_los());
    chk("R3 dpm_o", dpm, m_dpm());
    chk("R5 los_stat_o", los_s, m_ls);
    chk("R5 dpm_stat_o", dpm_s, m_ds);
    chk("R5 irq_no", irq_n, !(m_ls || m_ds));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R9 los", los, 0); chk("R9 dpm", dpm, 0);
    chk("R9 los_stat", los_s, 0); chk("R9 dpm_stat", dpm_s, 0); chk("R9 irq_no", irq_n, 1);
    rst_n = 1'b1;
    cyc(62);  chk("R3 dpm before window", dpm, 0);
    cyc(1);   chk("R3 dpm at window", dpm, 1);
    cyc(1);   chk("R5 dpm_stat set", dpm_s, 1); chk("R5 irq low", irq_n, 0);
    cyc(110); chk("R1 los at 174", los, 0);
    cyc(1);   chk("R1 los at 175", los, 1);
    cyc(250); chk("R8 los saturated", los, 1); chk("R8 dpm saturated", dpm, 1);
    cl = 1; cd = 1; cyc(1); cl = 0; cd = 0;
    chk("R7 los_stat kept", los_s, 1); chk("R7 dpm_stat kept", dpm_s, 1);
    mn = 1; cyc(1); mn = 0;
    chk("R2 los drop on neg mark", los, 0); chk("R10 dpm unaffected", dpm, 1);
    cl = 1; cyc(1); cl = 0;
    chk("R6 los_stat cleared", los_s, 0);
    chk("R10 dpm_stat kept", dpm_s, 1); chk("R5 irq still low", irq_n, 0);
    ma = 1; cyc(1);
    chk("R4 dpm drop", dpm, 0);
    cd = 1; cyc(1); cd = 0;
    chk("R6 dpm_stat cleared", dpm_s, 0); chk("R6 irq released", irq_n, 1);
    cyc(180); chk("R1 los again", los, 1);
    mp = 1; cyc(1); mp = 0;
    chk("R2 los drop on pos mark", los, 0);
    cl = 1; cyc(1); cl = 0;
    // random stretch at several densities
    for (int d = 0; d < 4; d++) begin
      for (int k = 0; k < 1500; k++) begin
        int lim = (d == 0) ? 2 : (d == 1) ? 40 : (d == 2) ? 150 : 400;
        mp = ($urandom % lim) == 0;
        mn = ($urandom % lim) == 0;
        ma = ($urandom % (lim / 2 + 1)) == 0;
        cl = ($urandom % 30) == 0;
        cd = ($urandom % 30) == 0;
        cyc(1);
      end
    end
    mp = 0; mn = 0; ma = 0; cl = 0; cd = 0;
    cyc(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule